// File: doc/BRIEF.md
# TDM Serial Input Deserializer with Programmable Alignment

This block takes one serial time-division-multiplexed input line and turns it into 8-bit channel bytes. A frame pulse marks the frame boundary. Each frame carries a fixed number of channels, and that number depends on the selected line rate: 2.048, 4.096, 8.192 or 16.384 Mbps. Each byte comes out on a parallel port together with its channel index and a one-clock valid strobe.

The block runs from a single oversampling clock. At the default parameters this clock gives 16, 8, 4 or 2 clocks per bit, one count for each rate. Two alignment controls let the receiver follow the wire delays of different sources:
- A whole-bit delay of 0 to 7 bits moves the start of channel 0 later after the frame boundary.
- A fractional sampling point chooses the clock inside each bit period at which the line is read.

Configuration is taken from static control inputs. A surrounding register block is expected to hold these inputs stable while the stream runs.

Top module: `tdmrx_deser`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `valid_o` is 0, `byte_o` is 0 and `chan_o` is 0.
- R2: The clock edge at which `frame_i` is high restarts the frame. Bit period 0 of the new frame takes the clock cycles that follow that edge. A pulse that arrives early (mid-frame) resynchronises the frame at once.
- R3: `rate_i` codes 0, 1, 2 and 3 select 2.048, 4.096, 8.192 and 16.384 Mbps. With the defaults, these give 16, 8, 4 and 2 clocks per bit.
- R4: At rate codes 0 to 2, `samp_i` codes 0, 1, 2 and 3 sample the line at 1/4, 2/4, 3/4 and 4/4 of the bit. The sample is taken on clock number (code+1)·cpb/4 − 1, counting from 0 within the bit, where cpb is the number of clocks per bit.
- R5: At rate code 3, bit 0 of `samp_i` is ignored. Codes 0 and 1 sample at 1/2 of the bit (clock 0). Codes 2 and 3 sample at 2/2 of the bit (clock 1).
- R6: Bits arrive MSB first. The first bit sampled for a channel lands in `byte_o[7]` and the last in `byte_o[0]`.
- R7: With `dly_i` = D, bit 7 of channel 0 is the bit period D after the boundary. The last D bits of the last channel fall after the next boundary.
- R8: `chan_o` steps 0, 1, …, last within a frame. The last index is (32 << rate code) − 1, so 31, 63, 127 or 255.
- R9: `valid_o` is high for exactly one clock. That clock is the one after the sample of a channel's bit 0, and there is one strobe per channel.
- R10: When no new frame pulse comes, the block keeps running with the same frame length. Channel numbering wraps from the last channel back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame pulse, one clock wide, active high |
| ser_i | input | 1 | Serial data line |
| rate_i | input | 2 | Line rate code |
| dly_i | input | 3 | Whole-bit delay, 0 to 7 |
| samp_i | input | 2 | Fractional sampling point code |
| byte_o | output | 8 | Assembled channel byte |
| chan_o | output | CH_LOG2+3 | Channel index of `byte_o` |
| valid_o | output | 1 | One-clock byte strobe |

## Verification
The bench builds the block with its default parameters: 16 clocks per bit at the slowest rate and 32 base channels. Every rate then has the same 4096-clock frame, so full frames at all four rates fit in one run. This covers the widest (16-clock) and the narrowest (2-clock) fractional grids, delays of both 0 and 7, channel indices up to 255, a frame with no following pulse, and an early resynchronising pulse. The bench presents the correct bit only on the one clock where a sample is expected and the inverted bit on every other clock, so any error in the sampling point shows up as a wrong byte.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X8 = 2'd3
  } rate_e;

  // Clocks per serial bit at a given rate code.
  function automatic int clks_per_bit(int ovs_log2, rate_e rate);
    return 1 << (ovs_log2 - int'(rate));
  endfunction

  // Bits per frame at a given rate code.
  function automatic int frame_bits(int ch_log2, rate_e rate);
    return 8 << (ch_log2 + int'(rate));
  endfunction

  // Highest channel index at a given rate code.
  function automatic int last_chan(int ch_log2, rate_e rate);
    return (1 << (ch_log2 + int'(rate))) - 1;
  endfunction

  // Clock within the bit on which the line is read.
  function automatic int sample_clk(int ovs_log2, rate_e rate, logic [1:0] code);
    int cpb;
    cpb = clks_per_bit(ovs_log2, rate);
    if (cpb < 4) begin
      return code[1] ? cpb - 1 : (cpb / 2) - 1;
    end
    return (int'(code) + 1) * (cpb / 4) - 1;
  endfunction

endpackage

// File: rtl/tdmrx_timing.sv
module tdmrx_timing #(
  parameter  int OVS_LOG2 = 4,
  parameter  int CH_LOG2  = 5,
  localparam int PH_W     = OVS_LOG2,
  localparam int CNT_W    = CH_LOG2 + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic [1:0]       rate_i,
  input  logic [2:0]       dly_i,
  input  logic [1:0]       samp_i,
  output logic             samp_evt_o,
  output logic [CNT_W-1:0] bitpos_o
);
  import tdmrx_pkg::*;

  logic [PH_W-1:0]  ph_q;
  logic [PH_W-1:0]  ph_last;
  logic [PH_W-1:0]  samp_idx;
  logic [CNT_W-1:0] bit_q;
  logic [CNT_W-1:0] fmask;
  logic [CNT_W-1:0] load_val;
  logic             bit_end;

  always_comb begin
    ph_last  = PH_W'(clks_per_bit(OVS_LOG2, rate_e'(rate_i)) - 1);
    samp_idx = PH_W'(sample_clk(OVS_LOG2, rate_e'(rate_i), samp_i));
    fmask    = CNT_W'(frame_bits(CH_LOG2, rate_e'(rate_i)) - 1);
    load_val = (CNT_W'(0) - CNT_W'(dly_i)) & fmask;
    bit_end  = (ph_q >= ph_last);
  end

  // The frame pulse reloads the bit counter with -D, so that channel 0 bit 7
  // lands D bit periods after the boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      bit_q <= '0;
    end else if (frame_i) begin
      ph_q  <= '0;
      bit_q <= load_val;
    end else if (bit_end) begin
      ph_q  <= '0;
      bit_q <= (bit_q + 1'b1) & fmask;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  assign samp_evt_o = (ph_q == samp_idx);
  assign bitpos_o   = bit_q;

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= ph_last);

  p_frame_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (ph_q == '0));

  p_single_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_evt_o && !frame_i) |=> !samp_evt_o);

endmodule

// File: rtl/tdmrx_shift.sv
module tdmrx_shift #(
  parameter  int CNT_W = 11,
  localparam int CH_W  = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_evt_i,
  input  logic             ser_i,
  input  logic [CNT_W-1:0] bitpos_i,
  output logic [7:0]       byte_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             valid_o
);
  logic [6:0] sh_q;
  logic       byte_done;

  assign byte_done = samp_evt_i && (bitpos_i[2:0] == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      byte_o  <= '0;
      chan_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= byte_done;
      if (samp_evt_i) sh_q <= {sh_q[5:0], ser_i};
      if (byte_done) begin
        byte_o <= {sh_q, ser_i};
        chan_o <= bitpos_i[CNT_W-1:3];
      end
    end
  end

  p_valid_after_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(samp_evt_i));

endmodule

// File: rtl/tdmrx_deser.sv
module tdmrx_deser #(
  parameter int OVS_LOG2 = 4,
  parameter int CH_LOG2  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_i,
  input  logic               ser_i,
  input  logic [1:0]         rate_i,
  input  logic [2:0]         dly_i,
  input  logic [1:0]         samp_i,
  output logic [7:0]         byte_o,
  output logic [CH_LOG2+2:0] chan_o,
  output logic               valid_o
);
  import tdmrx_pkg::*;

  localparam int CNT_W = CH_LOG2 + 6;

  logic             samp_evt;
  logic [CNT_W-1:0] bitpos;

  tdmrx_timing #(.OVS_LOG2(OVS_LOG2), .CH_LOG2(CH_LOG2)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_i),
    .rate_i     (rate_i),
    .dly_i      (dly_i),
    .samp_i     (samp_i),
    .samp_evt_o (samp_evt),
    .bitpos_o   (bitpos)
  );

  tdmrx_shift #(.CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_evt_i (samp_evt),
    .ser_i      (ser_i),
    .bitpos_i   (bitpos),
    .byte_o     (byte_o),
    .chan_o     (chan_o),
    .valid_o    (valid_o)
  );

  p_chan_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(chan_o) <= last_chan(CH_LOG2, rate_e'(rate_i))));

  p_valid_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: tb/tb_tdmrx_deser.sv
module tb_tdmrx_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_i = 1'b0;
  logic       ser_i = 1'b0;
  logic [1:0] rate_i = '0;
  logic [2:0] dly_i = '0;
  logic [1:0] samp_i = '0;
  logic [7:0] byte_o;
  logic [7:0] chan_o;
  logic       valid_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tdmrx_deser dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .ser_i(ser_i),
    .rate_i(rate_i), .dly_i(dly_i), .samp_i(samp_i),
    .byte_o(byte_o), .chan_o(chan_o), .valid_o(valid_o)
  );

  function automatic logic [7:0] pat(int w, int seed);
    return 8'(w * 53 + 17 + seed * 11);
  endfunction

  // Monitor: compare each strobe against the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected strobe got chan=%0d byte=%02h exp none", chan_o, byte_o);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({chan_o, byte_o} !== e) begin
          failures++;
          $display("FAIL %s got chan=%0d byte=%02h exp chan=%0d byte=%02h",
                   t, chan_o, byte_o, e[15:8], e[7:0]);
        end
      end
    end
  end

  // Driver: drive one segment and push the expected items. For each cycle the
  // line carries the true bit only on the expected sample clock.
  task automatic run_seg(input int rate, input int dly, input int sc,
                         input int p2, input int len, input int seed, input string tag);
    int cpb, bpf, nch, sidx, pl, f, t, q, k, b, g, bs;
    logic bitv;
    logic [7:0] msh;
    cpb = 16 >> rate;
    bpf = 256 << rate;
    nch = 32 << rate;
    if (rate == 3) sidx = (sc >= 2) ? 1 : 0;   // R5 half-bit grid
    else sidx = (cpb * (sc + 1)) / 4 - 1;      // R4 quarter-bit grid
    msh = '0;
    rate_i = 2'(rate); dly_i = 3'(dly); samp_i = 2'(sc);
    frame_i = 1'b0; ser_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;   // R1 reset state
    if (valid_o !== 1'b0 || byte_o !== 8'h00 || chan_o !== 8'h00) begin
      failures++;
      $display("FAIL R1 got valid=%0b byte=%02h chan=%0d exp 0/00/0", valid_o, byte_o, chan_o);
    end
    rst_n = 1'b1;
    for (int n = -2; n <= len; n++) begin
      @(negedge clk);
      frame_i = (n == 0) || (p2 > 0 && n == p2);
      if (n <= 0) begin
        ser_i = 1'b0;
      end else begin
        pl = (p2 > 0 && n > p2) ? p2 : 0;
        f  = (pl == 0) ? 0 : 1;
        t  = n - pl - 1;
        q  = t / cpb;
        k  = t % cpb;
        b  = q % bpf;
        f  = f + q / bpf;                      // R10 free-running wrap
        g  = (f + 1) * bpf + b - dly;          // R7 delay offset
        bs = 7 - (g % 8);                      // R6 MSB first
        bitv = pat(g / 8, seed)[bs];
        if (k == sidx) begin
          ser_i = bitv;
          msh = {msh[6:0], bitv};
          if (bs == 0) begin
            exp_q.push_back({8'((g / 8) % nch), msh});
            tag_q.push_back(tag);
          end
        end else begin
          ser_i = ~bitv;
        end
      end
    end
    @(negedge clk);
    #1;
    checks++;   // R9 one strobe per channel: all expected items consumed
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9 missing strobes got %0d pending exp 0", exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
    rst_n = 1'b0;
  endtask

  initial begin
    run_seg(0, 0, 2, 4096, 8200, 1, "R3 R4 R6 R8 rate0");
    run_seg(1, 3, 0, 4096, 8200, 2, "R4 R7 rate1");
    run_seg(2, 7, 3, 4096, 8200, 3, "R4 R7 R8 rate2");
    run_seg(3, 5, 0, 4096, 8200, 4, "R5 R7 rate3 half");
    run_seg(3, 2, 3, 4096, 8200, 5, "R5 rate3 full");
    run_seg(3, 0, 1, 4096, 8200, 6, "R5 lsb ignored");
    run_seg(0, 1, 1, 0,    8200, 7, "R10 free run");
    run_seg(2, 4, 2, 2500, 8200, 8, "R2 early resync");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog got %0d cycles exp completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule